// File: doc/BRIEF.md
# DRAM Timing Configuration Register

This block is one 32-bit memory-mapped register inside a DRAM controller. It holds the programmable AC timing values of the attached SDRAM, each counted in memory clock cycles minus one. The register bus supplies a decoded write strobe, a read strobe and a 32-bit data word. There is no byte-lane access: every write replaces the whole word. Each timing field leaves the block on a port of its own, so the command scheduler reads its limits without going through the bus.

A separate configuration register supplies a timing-unlock input. While that input is low, writes are dropped. The block also watches the write-recovery field. When an accepted write changes that field while the controller-enable input is high, the block sends the initialization sequencer a single-cycle request.

The block also checks one rule between two fields. The activate-to-precharge time must not be shorter than the activate-to-read/write delay. If an accepted write breaks this rule, a sticky error flag is set. A read of the register clears the flag.

Top module: `dram_timing_reg`

## Requirements
- R1: After reset the fields hold these values: refresh cycle 0x3F, precharge 0x7, activate-to-read/write 0x7, write recovery 0x7, activate-to-precharge 0x1F, activate-to-activate 0x1F, activate-to-activate across banks 0x7, write-to-read 0x3. The read word is 0x7FFFFFFB. The init request and the error flag are low.
- R2: A write with `wr_en` and `unlock` both high updates every field at the next clock edge. The fields sit at these word bits: refresh cycle 31:25, precharge 24:22, activate-to-read/write 21:19, write recovery 18:16, activate-to-precharge 15:11, activate-to-activate 10:6, activate-to-activate across banks 5:3, write-to-read 1:0. Each field appears on its own output port.
- R3: Bit 2 is reserved. It always reads 0, and writing a 1 to it has no effect.
- R4: A write made while `unlock` is low changes no field.
- R5: While `rd_en` is high, `rdata` returns the full register word in the same cycle. While `rd_en` is low, `rdata` is 0.
- R6: An accepted write whose write-recovery value (word bits 18:16) differs from the held value, made while `ctrl_en` is 1, raises `init_req` for exactly the one cycle after the write's clock edge.
- R7: No `init_req` is produced in these cases: the write-recovery value is unchanged, `ctrl_en` is 0, or the write is locked.
- R8: `order_err` is set by an accepted write that leaves the activate-to-precharge field (bits 15:11) smaller than the activate-to-read/write field (bits 21:19). Later writes that obey the rule do not clear it.
- R9: A read clears `order_err` at its clock edge. If a rule-breaking accepted write falls in the same cycle as the read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Decoded register write strobe |
| rd_en | input | 1 | Decoded register read strobe |
| wdata | input | 32 | Write data word |
| rdata | output | 32 | Read data word, valid in the strobe cycle |
| unlock | input | 1 | Timing-write unlock from the configuration register |
| ctrl_en | input | 1 | Controller enabled |
| cyc_refresh | output | 7 | Refresh cycle time |
| cyc_precharge | output | 3 | Precharge period |
| cyc_act_rw | output | 3 | Activate to read/write delay |
| cyc_wr_recov | output | 3 | Write recovery time |
| cyc_act_pre | output | 5 | Activate to precharge time |
| cyc_act_act | output | 5 | Activate to activate, same bank |
| cyc_act_act_bank | output | 3 | Activate to activate, different banks |
| cyc_wr_rd | output | 2 | Write to read turnaround |
| init_req | output | 1 | Single-cycle initialization request |
| order_err | output | 1 | Sticky field-ordering error |

## Verification
The hardest case to reach is a read and a rule-breaking write landing in the same cycle. In that cycle the clearing and the setting of the error flag collide. The bench drives both strobes in one cycle to cover it. It also runs a sweep over every pairing of the activate-to-precharge and activate-to-read/write values, and after each write it reads the register to clear the flag. The bench then sweeps every write-recovery value twice, once with a changed value and once with a repeated one, and covers locked writes with `ctrl_en` high. These runs separate a genuine change from a rewrite of the same value.

// File: rtl/dtr_pkg.sv
package dtr_pkg;
   localparam int DTR_W = 32;
   typedef logic [DTR_W-1:0] dtr_word_t;
endpackage

// File: rtl/dtr_field.sv
module dtr_field #(
   parameter int W   = 3,
   parameter int RST = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= W'(RST);
      else if (load) q <= d;
   end
endmodule

// File: rtl/dtr_reinit.sv
module dtr_reinit #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         acc,
   input  logic         en,
   input  logic [W-1:0] new_val,
   input  logic [W-1:0] cur_val,
   output logic         pulse
);
   always_ff @(posedge clk) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= acc && en && (new_val != cur_val);
   end

   AST_INIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> ($past(acc) && $past(en))); // R6
   AST_INIT_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && new_val == cur_val) |=> !pulse); // R7
   AST_INIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pulse); // R7
endmodule

// File: rtl/dtr_order_mon.sv
module dtr_order_mon #(
   parameter int WA = 5,
   parameter int WB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc,
   input  logic          rd,
   input  logic [WA-1:0] new_long,
   input  logic [WB-1:0] new_short,
   output logic          err
);
   localparam int WM = (WA > WB) ? WA : WB;
   logic [WM-1:0] long_x, short_x;
   logic          bad;

   assign long_x  = WM'(new_long);
   assign short_x = WM'(new_short);
   assign bad     = acc && (long_x < short_x);

   always_ff @(posedge clk) begin
      if (!rst_n)   err <= 1'b0;
      else if (bad) err <= 1'b1;
      else if (rd)  err <= 1'b0;
   end

   AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> err); // R8
   AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !bad) |=> !err); // R9
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !rd) |=> err); // R8
endmodule

// File: rtl/dram_timing_reg.sv
module dram_timing_reg
   import dtr_pkg::*;
#(
   parameter int W_REF   = 7,
   parameter int W_PRE   = 3,
   parameter int W_ARW   = 3,
   parameter int W_WRC   = 3,
   parameter int W_APR   = 5,
   parameter int W_AAC   = 5,
   parameter int W_AAB   = 3,
   parameter int W_W2R   = 2,
   parameter int RST_REF = 63,
   parameter int RST_PRE = 7,
   parameter int RST_ARW = 7,
   parameter int RST_WRC = 7,
   parameter int RST_APR = 31,
   parameter int RST_AAC = 31,
   parameter int RST_AAB = 7,
   parameter int RST_W2R = 3,
   parameter bit RD_ZERO_IDLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [31:0]      wdata,
   output logic [31:0]      rdata,
   input  logic             unlock,
   input  logic             ctrl_en,
   output logic [W_REF-1:0] cyc_refresh,
   output logic [W_PRE-1:0] cyc_precharge,
   output logic [W_ARW-1:0] cyc_act_rw,
   output logic [W_WRC-1:0] cyc_wr_recov,
   output logic [W_APR-1:0] cyc_act_pre,
   output logic [W_AAC-1:0] cyc_act_act,
   output logic [W_AAB-1:0] cyc_act_act_bank,
   output logic [W_W2R-1:0] cyc_wr_rd,
   output logic             init_req,
   output logic             order_err
);
   localparam int L_W2R = 0;
   localparam int L_RSV = L_W2R + W_W2R;
   localparam int L_AAB = L_RSV + 1;
   localparam int L_AAC = L_AAB + W_AAB;
   localparam int L_APR = L_AAC + W_AAC;
   localparam int L_WRC = L_APR + W_APR;
   localparam int L_ARW = L_WRC + W_WRC;
   localparam int L_PRE = L_ARW + W_ARW;
   localparam int L_REF = L_PRE + W_PRE;
   localparam int L_TOP = L_REF + W_REF;
   localparam dtr_word_t RSV_MASK = dtr_word_t'(1) << L_RSV;

   generate
      if (L_TOP != DTR_W) begin : g_bad_layout
         $error("dram_timing_reg: field widths must fill the word");
      end
      if (RST_REF >= (1 << W_REF) || RST_PRE >= (1 << W_PRE) ||
          RST_ARW >= (1 << W_ARW) || RST_WRC >= (1 << W_WRC) ||
          RST_APR >= (1 << W_APR) || RST_AAC >= (1 << W_AAC) ||
          RST_AAB >= (1 << W_AAB) || RST_W2R >= (1 << W_W2R)) begin : g_bad_reset
         $error("dram_timing_reg: reset value exceeds field width");
      end
   endgenerate

   logic      wr_acc;
   dtr_word_t held_word;

   assign wr_acc = wr_en && unlock;

   dtr_field #(.W(W_REF), .RST(RST_REF)) u_ref (.clk(clk), .rst_n(rst_n), .load(wr_acc),
      .d(wdata[L_REF +: W_REF]), .q(cyc_refresh));
   dtr_field #(.W(W_PRE), .RST(RST_PRE)) u_pre (.clk(clk), .rst_n(rst_n), .load(wr_acc),
      .d(wdata[L_PRE +: W_PRE]), .q(cyc_precharge));
   dtr_field #(.W(W_ARW), .RST(RST_ARW)) u_arw (.clk(clk), .rst_n(rst_n), .load(wr_acc),
      .d(wdata[L_ARW +: W_ARW]), .q(cyc_act_rw));
   dtr_field #(.W(W_WRC), .RST(RST_WRC)) u_wrc (.clk(clk), .rst_n(rst_n), .load(wr_acc),
      .d(wdata[L_WRC +: W_WRC]), .q(cyc_wr_recov));
   dtr_field #(.W(W_APR), .RST(RST_APR)) u_apr (.clk(clk), .rst_n(rst_n), .load(wr_acc),
      .d(wdata[L_APR +: W_APR]), .q(cyc_act_pre));
   dtr_field #(.W(W_AAC), .RST(RST_AAC)) u_aac (.clk(clk), .rst_n(rst_n), .load(wr_acc),
      .d(wdata[L_AAC +: W_AAC]), .q(cyc_act_act));
   dtr_field #(.W(W_AAB), .RST(RST_AAB)) u_aab (.clk(clk), .rst_n(rst_n), .load(wr_acc),
      .d(wdata[L_AAB +: W_AAB]), .q(cyc_act_act_bank));
   dtr_field #(.W(W_W2R), .RST(RST_W2R)) u_w2r (.clk(clk), .rst_n(rst_n), .load(wr_acc),
      .d(wdata[L_W2R +: W_W2R]), .q(cyc_wr_rd));

   assign held_word = {cyc_refresh, cyc_precharge, cyc_act_rw, cyc_wr_recov,
                       cyc_act_pre, cyc_act_act, cyc_act_act_bank, 1'b0, cyc_wr_rd};

   generate
      if (RD_ZERO_IDLE) begin : g_rd_gated
         assign rdata = rd_en ? held_word : '0;
         AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |-> (rdata == '0)); // R5
      end else begin : g_rd_open
         assign rdata = held_word;
      end
   endgenerate

   dtr_reinit #(.W(W_WRC)) u_reinit (
      .clk(clk), .rst_n(rst_n), .acc(wr_acc), .en(ctrl_en),
      .new_val(wdata[L_WRC +: W_WRC]), .cur_val(cyc_wr_recov), .pulse(init_req));

   dtr_order_mon #(.WA(W_APR), .WB(W_ARW)) u_order (
      .clk(clk), .rst_n(rst_n), .acc(wr_acc), .rd(rd_en),
      .new_long(wdata[L_APR +: W_APR]), .new_short(wdata[L_ARW +: W_ARW]), .err(order_err));

   AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !unlock) |=> $stable(held_word)); // R4
   AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_acc |=> (held_word == ($past(wdata) & ~RSV_MASK))); // R2
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[L_RSV] == 1'b0); // R3
endmodule

// File: tb/tb_dram_timing_reg.sv
`timescale 1ns/1ps
module tb_dram_timing_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        unlock = 1'b0;
   logic        ctrl_en = 1'b0;
   logic [6:0]  cyc_refresh;
   logic [2:0]  cyc_precharge, cyc_act_rw, cyc_wr_recov, cyc_act_act_bank;
   logic [4:0]  cyc_act_pre, cyc_act_act;
   logic [1:0]  cyc_wr_rd;
   logic        init_req, order_err;

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_word;
   logic        exp_err;
   logic [31:0] lfsr = 32'h1D2C_3B4A;

   always #2.5 clk = ~clk;

   dram_timing_reg dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
      .unlock(unlock), .ctrl_en(ctrl_en), .cyc_refresh(cyc_refresh),
      .cyc_precharge(cyc_precharge), .cyc_act_rw(cyc_act_rw), .cyc_wr_recov(cyc_wr_recov),
      .cyc_act_pre(cyc_act_pre), .cyc_act_act(cyc_act_act), .cyc_act_act_bank(cyc_act_act_bank),
      .cyc_wr_rd(cyc_wr_rd), .init_req(init_req), .order_err(order_err));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ports_word();
      return {cyc_refresh, cyc_precharge, cyc_act_rw, cyc_wr_recov,
              cyc_act_pre, cyc_act_act, cyc_act_act_bank, 1'b0, cyc_wr_rd};
   endfunction

   task automatic write_word(input logic [31:0] w, input string req);
      logic [2:0] old_wrc;
      logic       exp_init;
      old_wrc = exp_word[18:16];
      @(negedge clk);
      wr_en = 1'b1; wdata = w;
      @(negedge clk);
      wr_en = 1'b0;
      exp_init = unlock && ctrl_en && (w[18:16] != old_wrc);
      if (unlock) begin
         exp_word = w & ~32'h4;
         if (w[15:11] < {2'b00, w[21:19]}) exp_err = 1'b1;
      end
      chk(ports_word() == exp_word, {req, " fields (R2/R4)"}, ports_word(), exp_word);
      chk(init_req == exp_init, {req, " init pulse (R6/R7)"}, 32'(init_req), 32'(exp_init));
      chk(order_err == exp_err, {req, " order flag (R8)"}, 32'(order_err), 32'(exp_err));
      @(negedge clk);
      chk(init_req == 1'b0, {req, " single-cycle pulse R6"}, 32'(init_req), 32'h0);
   endtask

   task automatic read_word(input string req);
      @(negedge clk);
      chk(rdata == 32'h0, {req, " idle rdata R5"}, rdata, 32'h0);
      rd_en = 1'b1;
      #1;
      chk(rdata == exp_word, {req, " read word R5"}, rdata, exp_word);
      chk(rdata[2] == 1'b0, {req, " reserved bit R3"}, 32'(rdata[2]), 32'h0);
      @(negedge clk);
      rd_en = 1'b0;
      exp_err = 1'b0;
      chk(order_err == 1'b0, {req, " read clears flag R9"}, 32'(order_err), 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      exp_word = {7'd63, 3'd7, 3'd7, 3'd7, 5'd31, 5'd31, 3'd7, 1'b0, 2'd3};
      exp_err  = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ports_word() == exp_word, "reset fields R1", ports_word(), exp_word);
      chk(exp_word == 32'h7FFF_FFFB, "reset word R1", exp_word, 32'h7FFF_FFFB);
      chk(init_req == 1'b0 && order_err == 1'b0, "reset flags R1",
          {30'd0, init_req, order_err}, 32'h0);
      read_word("reset R1");

      // R4: locked writes, with and without controller enable
      write_word(32'h0000_0000, "locked R4");
      ctrl_en = 1'b1;
      write_word(32'h1234_0000, "locked enabled R4 R7");
      read_word("after locked R4");

      // R2: field layout under varied patterns, controller off (R7)
      unlock = 1'b1; ctrl_en = 1'b0;
      for (int i = 0; i < 40; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         write_word(lfsr, "pattern R2");
         read_word("pattern R2");
      end
      write_word(32'hFFFF_FFFF, "all ones R3");
      read_word("all ones R3");

      // R6/R7: every write-recovery value, changed then repeated
      ctrl_en = 1'b1;
      for (int v = 0; v < 8; v++) begin
         logic [31:0] w;
         w = (exp_word & ~32'h0007_0000) | (32'(v) << 16);
         write_word(w, "wr-recovery change R6");
         write_word(w ^ 32'h0000_0040, "wr-recovery repeat R7");
      end

      // R8/R9: every activate-to-precharge vs activate-to-read/write pairing
      for (int a = 0; a < 32; a++) begin
         for (int b = 0; b < 8; b++) begin
            write_word({7'd10, 3'd2, 3'(b), 3'd4, 5'(a), 5'd9, 3'd1, 1'b1, 2'd1}, "order sweep R8");
            read_word("order sweep R9");
         end
      end

      // R8: sticky across a later write that obeys the rule
      write_word({7'd5, 3'd1, 3'd6, 3'd2, 5'd3, 5'd4, 3'd2, 1'b0, 2'd2}, "bad write R8");
      write_word({7'd5, 3'd1, 3'd1, 3'd2, 5'd9, 5'd4, 3'd2, 1'b0, 2'd2}, "sticky R8");

      // R9: rule-breaking write and read in the same cycle
      @(negedge clk);
      wr_en = 1'b1; rd_en = 1'b1;
      wdata = {7'd5, 3'd1, 3'd7, 3'd2, 5'd2, 5'd4, 3'd2, 1'b0, 2'd2};
      #1;
      chk(rdata == exp_word, "collision read old word R5", rdata, exp_word);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      exp_word = wdata;
      exp_err  = 1'b1;
      chk(order_err == 1'b1, "collision keeps flag R9", 32'(order_err), 32'h1);
      read_word("after collision R9");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule